// File: doc/BRIEF.md
# Coprocessor Busy and Error Latch

This block drives the busy line that a CPU watches while its numeric coprocessor is working. As long as no coprocessor fault is pending, the CPU busy line is simply the coprocessor busy line, resynchronised into the system clock. When the coprocessor signals a fault, the block holds CPU busy active and raises an interrupt request. The request goes to interrupt level 13 of the system interrupt controller. The CPU's own error input is tied inactive outside this block.

Both the held busy and the interrupt request stay set until software performs an I/O write to port 00F0h. The coprocessor fault line may still be active when that write arrives, because the coprocessor clears it only after further accesses. For this reason the block sets its fault flag on the falling edge of the fault line, not on its level. A fault that is still held after the acknowledge therefore does not set the flag again.

Both coprocessor inputs come in through a synchroniser of `SYNC_STAGES` flops. The I/O write strobe and address are taken to be synchronous to `clk`. Reset is asserted asynchronously and released on a clock edge.

Top module: `fpu_busy_latch`

## Requirements
- R1: After reset, with both coprocessor inputs inactive (high), `cpu_busy_n` is 1 and `err_irq` is 0.
- R2: With no fault pending, `cpu_busy_n` equals `cop_busy_n` delayed by exactly `SYNC_STAGES` clock edges (2 by default).
- R3: A high-to-low transition of `cop_err_n` sets the fault flag `SYNC_STAGES`+1 clock edges later. While the flag is set, `err_irq` is 1 and `cpu_busy_n` is 0, whatever `cop_busy_n` does.
- R4: A clock edge at which `io_wr` is 1 and `io_addr` equals 16'h00F0 clears the fault flag at that edge. From then on, `cpu_busy_n` follows `cop_busy_n` again and `err_irq` is 0.
- R5: Writes to any other address, compared over all 16 bits (for example 00F1h, 01F0h and 80F0h), have no effect on the fault flag. So does address 00F0h presented with `io_wr` at 0.
- R6: A `cop_err_n` that is held low after the acknowledge does not set the flag again. Only a new high-to-low transition sets it.
- R7: When a fault edge and an acknowledge write act on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| cop_busy_n | input | 1 | Coprocessor busy, active low, asynchronous |
| cop_err_n | input | 1 | Coprocessor fault, active low, asynchronous |
| io_wr | input | 1 | I/O write strobe, one cycle per write, synchronous to clk |
| io_addr | input | 16 | I/O address qualified by io_wr |
| cpu_busy_n | output | 1 | Busy to the CPU, active low |
| err_irq | output | 1 | Interrupt request for the coprocessor fault, active high |

## Verification
The two functions that can meet in one cycle are setting the fault flag and acknowledging it through port 00F0h. The bench provokes this by driving `cop_err_n` low, counting the synchroniser and edge-detect edges, and placing the acknowledge write on exactly the edge at which the detected fault edge reaches the flag. It does this twice: once from a clear flag, and once after an earlier fault has been released and then raised again. In both cases it expects `err_irq` high and `cpu_busy_n` low at the next sample. A design in which the acknowledge wins would lose the second fault.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  localparam int unsigned IO_ADDR_W = 16;
  localparam logic [IO_ADDR_W-1:0] ACK_PORT = 16'h00F0;

  typedef struct packed {
    logic busy;
    logic err;
  } cop_st_t;

  localparam int unsigned COP_W = $bits(cop_st_t);
endpackage

// File: rtl/fbl_rst_sync.sv
module fbl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/fbl_sync.sv
module fbl_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (i == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/fbl_port_dec.sv
module fbl_port_dec #(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    ACK_ADDR = ADDR_W'(16'h00F0)
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              ack_hit
);
  always_comb begin
    ack_hit = io_wr && (io_addr == ACK_ADDR);
  end
endmodule

// File: rtl/fbl_err_latch.sv
module fbl_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic err_s,
  input  logic ack,
  output logic flag_q,
  output logic err_edge
);
  logic err_prev_q;
  logic flag_d;
  logic flag_en;

  // next state: a fresh fault edge outranks the acknowledge
  always_comb begin
    err_edge = err_s && !err_prev_q;
    flag_en  = err_edge || ack;
    flag_d   = err_edge ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_prev_q <= 1'b0;
    else        err_prev_q <= err_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assert_err_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_edge |=> flag_q);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err_edge) |=> !flag_q);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !err_edge) |=> $stable(flag_q));

  assert_set_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err_edge) |=> flag_q);
endmodule

// File: rtl/fpu_busy_latch.sv
module fpu_busy_latch #(
  parameter int unsigned                     SYNC_STAGES = 2,
  parameter int unsigned                     ADDR_W      = fbl_pkg::IO_ADDR_W,
  parameter logic [ADDR_W-1:0]               ACK_ADDR    = ADDR_W'(fbl_pkg::ACK_PORT)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cop_busy_n,
  input  logic              cop_err_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              cpu_busy_n,
  output logic              err_irq
);
  import fbl_pkg::*;

  logic    rst_n;
  cop_st_t cop_raw;
  cop_st_t cop_s;
  logic    ack_hit;
  logic    flag_q;
  logic    err_edge;

  fbl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  always_comb begin
    cop_raw.busy = !cop_busy_n;
    cop_raw.err  = !cop_err_n;
  end

  fbl_sync #(.WIDTH(COP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cop_raw),
    .dout  (cop_s)
  );

  fbl_port_dec #(.ADDR_W(ADDR_W), .ACK_ADDR(ACK_ADDR)) u_dec (
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .ack_hit (ack_hit)
  );

  fbl_err_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_s    (cop_s.err),
    .ack      (ack_hit),
    .flag_q   (flag_q),
    .err_edge (err_edge)
  );

  always_comb begin
    cpu_busy_n = !(cop_s.busy || flag_q);
    err_irq    = flag_q;
  end

  assert_irq_forces_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !cpu_busy_n);

  assert_other_port_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_wr && io_addr == ACK_ADDR) && !err_edge) |=> (err_irq == $past(err_irq)));
endmodule

// File: tb/fpu_busy_latch_tb.sv
`timescale 1ns/1ps
module fpu_busy_latch_tb;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        cop_busy_n;
  logic        cop_err_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic        cpu_busy_n;
  logic        err_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fpu_busy_latch u_dut (
    .clk        (clk),
    .arst_n     (arst_n),
    .cop_busy_n (cop_busy_n),
    .cop_err_n  (cop_err_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .cpu_busy_n (cpu_busy_n),
    .err_irq    (err_irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compares {cpu_busy_n, err_irq}
  task automatic check(input string req, input logic [1:0] exp);
    n_run++;
    if ({cpu_busy_n, err_irq} !== exp) begin
      n_fail++;
      $display("FAIL %s: {busy_n,irq} actual %b expected %b at %0t", req, {cpu_busy_n, err_irq}, exp, $time);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic wr);
    io_addr = a; io_wr = wr;
    step(1);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic t_reset;
    cop_busy_n = 1'b1; cop_err_n = 1'b1; io_wr = 1'b0; io_addr = 16'h0;
    arst_n = 1'b0;
    step(3);
    arst_n = 1'b1;
    step(6);
    check("R1", 2'b10);
  endtask

  task automatic t_passthrough;
    cop_busy_n = 1'b0;
    step(1); check("R2 latency-1", 2'b10);
    step(1); check("R2 asserted", 2'b00);
    cop_busy_n = 1'b1;
    step(1); check("R2 hold", 2'b00);
    step(1); check("R2 released", 2'b10);
  endtask

  task automatic t_error_latch;
    cop_err_n = 1'b0;
    step(2); check("R3 not yet", 2'b10);
    step(1); check("R3 set", 2'b01);
    cop_busy_n = 1'b0; step(3); check("R3 busy active", 2'b01);
    cop_busy_n = 1'b1; step(3); check("R3 busy released", 2'b01);
  endtask

  task automatic t_other_ports;
    io_write(16'h00F1, 1'b1); check("R5 00F1", 2'b01);
    io_write(16'h01F0, 1'b1); check("R5 01F0", 2'b01);
    io_write(16'h80F0, 1'b1); check("R5 80F0", 2'b01);
    io_write(16'h00F0, 1'b0); check("R5 no strobe", 2'b01);
  endtask

  task automatic t_clear;
    // fault still held low here
    io_write(16'h00F0, 1'b1); check("R4 cleared", 2'b10);
    cop_busy_n = 1'b0; step(2); check("R4 follows again", 2'b00);
    cop_busy_n = 1'b1; step(2); check("R4 follows release", 2'b10);
  endtask

  task automatic t_held_error;
    step(8); check("R6 held fault no relatch", 2'b10);
    cop_err_n = 1'b1; step(4); check("R6 fault released", 2'b10);
    cop_err_n = 1'b0; step(3); check("R6 new edge sets", 2'b01);
    io_write(16'h00F0, 1'b1); check("R4 clear again", 2'b10);
    cop_err_n = 1'b1; step(4);
  endtask

  task automatic t_same_cycle;
    // from clear flag: fault edge and ack on the same edge
    cop_err_n = 1'b0;
    step(2);
    io_write(16'h00F0, 1'b1);
    check("R7 set wins from clear", 2'b01);
    step(3); check("R7 stays set", 2'b01);
    // second fault while flag already set
    cop_err_n = 1'b1; step(4);
    cop_err_n = 1'b0;
    step(2);
    io_write(16'h00F0, 1'b1);
    check("R7 set wins from set", 2'b01);
    io_write(16'h00F0, 1'b1); check("R4 final clear", 2'b10);
    cop_err_n = 1'b1; step(4); check("R2 idle end", 2'b10);
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_error_latch();
    t_other_ports();
    t_clear();
    t_held_error();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule